// File: doc/BRIEF.md
# Cartridge ROM Read Cache

This block sits between the cartridge bus of an emulated handheld console and a 64-bit read initiator that pulls ROM contents out of shared DRAM. The console presents a byte address together with a read or write strobe and expects the access to finish inside one of its own bus cycles. DRAM latency is variable, so the block keeps recently used 8-byte lines in a direct-mapped store. A read that hits is answered in the same cycle. A read that misses starts a single line fill, and the block holds the console core's clock enable low until the line arrives. The core therefore sees every access complete in what it counts as one cycle.

Writes, which target the cartridge RAM region, are never cached. They pass straight through to the initiator, and the core is frozen until the initiator accepts them. A free-running counter reports how many cycles the core has spent frozen. Changing the DRAM base address of the ROM image discards every cached line, as a reset does. Back-to-back hits are served one per cycle, so the double-speed console mode, which issues accesses twice as often, adds no stall for data that is already resident.

Top module: `cart_rom_cache`

## Requirements
- R1: After reset every line is invalid, `core_ce` is 1, `mem_req_valid` is 0 and `stall_count` is 0. The first read of any address after a reset is a miss.
- R2: A read miss drives `core_ce` low in the cycle it is presented. It then issues one request with `mem_req_write`=0 and `mem_req_addr` = `rom_base` + (console address with its low 3 bits cleared). In the cycle `mem_rsp_valid` is 1, the block returns byte lane `off` of `mem_rsp_data` (bits 8*off+7 down to 8*off, where off is address bits 2:0) on `cons_rdata`, with `cons_rvalid`=1 and `core_ce`=1.
- R3: A read that hits returns its byte on `cons_rdata`, with `cons_rvalid`=1 and `core_ce`=1, in the cycle it is presented, and issues no memory request.
- R4: The cache is direct mapped. Address bits 11:3 select the line and the bits above 11 form the tag. A fill for one tag replaces whatever tag held that line, so two addresses 4096 bytes apart evict each other.
- R5: `stall_count` rises by exactly 1 at each clock edge where `core_ce` was 0 and holds otherwise. A miss therefore costs 2 + (cycles waiting for `mem_req_ready`) + (response latency − 1) counts.
- R6: Reads that hit can be presented in consecutive cycles, and each completes in its own cycle with no stall.
- R7: A change of `rom_base` invalidates all lines. A read presented in the same cycle as the change, or later, misses and fetches from the new base.
- R8: A write (`cons_wr`=1, `cons_rd`=0) holds `core_ce` low until the initiator accepts it. It sends `mem_req_write`=1, `mem_req_addr` = the console address zero-extended, and `mem_req_wdata` = `cons_wdata`. It leaves cached lines untouched, so a later read of a cached address still hits with the old byte.
- R9: `mem_req_valid`, once high, stays high with `mem_req_addr`, `mem_req_write` and `mem_req_wdata` unchanged until `mem_req_ready` is 1. Responses have no ready signal: the block takes `mem_rsp_valid` only while waiting for a fill and ignores it at any other time.
- R10: If `rom_base` changes while a fill is outstanding, the fetched byte is still returned to the console, but the line is not marked valid, so the next read of that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_base | input | MEM_AW | DRAM byte address where the ROM image starts |
| cons_rd | input | 1 | Console read strobe, held until `core_ce` is 1 |
| cons_wr | input | 1 | Console write strobe, held until `core_ce` is 1 |
| cons_addr | input | ADDR_W | Console byte address |
| cons_wdata | input | 8 | Console write byte |
| cons_rdata | output | 8 | Read byte, meaningful when `cons_rvalid` is 1 |
| cons_rvalid | output | 1 | Read data valid this cycle |
| core_ce | output | 1 | Clock enable for the emulated core |
| mem_req_valid | output | 1 | Request to the initiator is valid |
| mem_req_ready | input | 1 | Initiator accepts the request |
| mem_req_write | output | 1 | 1 = byte write, 0 = line read |
| mem_req_addr | output | MEM_AW | Request byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Fill data valid (no back-pressure) |
| mem_rsp_data | input | 8*LINE_BYTES | Fill line, byte lane i holds address base+i |
| stall_count | output | STALL_W | Count of cycles with `core_ce` low |

## Verification
The bench aims at the cycles where a cache of this kind tends to lie. The first is a base change in the same cycle as a read: a design that looked up before invalidating would return a byte from the old image. The second is a base change during a fill: a design that validated the line anyway would later serve the old image from a hit. The bench also uses two addresses 4096 bytes apart to catch a wrong index or tag split, which would show up as a false hit or a lost eviction. It holds `mem_req_ready` low for several cycles to catch a request that changes or drops before acceptance and a stall count that is off by one. It checks that a write does not update or invalidate the resident line, and it injects a stray response while the block is idle, which must not produce a data strobe.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/crc_tag_store.sv
module crc_tag_store #(
  parameter int LINES = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             raw_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // valid bits live in flops so a flush clears every line in one edge
  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (flush) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign raw_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
endmodule

// File: rtl/crc_line_store.sv
module crc_line_store #(
  parameter int LINES  = 512,
  parameter int IDX_W  = 9,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
  end

  assign rd_line = mem_q[rd_idx];
endmodule

// File: rtl/crc_byte_pick.sv
module crc_byte_pick #(
  parameter int LINE_BYTES = 8,
  parameter int OFF_W      = 3
) (
  input  logic [8*LINE_BYTES-1:0] line_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic [7:0]              byte_o
);
  logic [7:0] lanes [LINE_BYTES];

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    assign lanes[g] = line_i[8*g +: 8];
  end

  assign byte_o = lanes[off_i];
endmodule

// File: rtl/crc_fill_fsm.sv
module crc_fill_fsm
  import crc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int MEM_AW = 32,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              lookup_hit,
  input  logic              base_chg,
  input  logic [MEM_AW-1:0] rom_base,
  input  logic [ADDR_W-1:0] cons_addr,
  input  logic [7:0]        cons_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [MEM_AW-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  output logic [ADDR_W-1:0] held_addr,
  output logic              fill_we,
  output logic              fill_done,
  output logic              core_ce,
  output logic              in_idle
);
  fill_state_e state_q, state_d;
  logic              wr_q;
  logic              stale_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [MEM_AW-1:0] maddr_q;
  logic              start;
  logic [MEM_AW-1:0] line_addr;

  assign line_addr = rom_base + MEM_AW'({cons_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
  assign start     = (state_q == FS_IDLE) &&
                     ((rd_req && !lookup_hit) || (wr_req && !rd_req));

  always_comb begin
    state_d   = state_q;
    core_ce   = 1'b1;
    fill_we   = 1'b0;
    fill_done = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (start) begin
          state_d = FS_REQ;
          core_ce = 1'b0;
        end
      end
      FS_REQ: begin
        core_ce = 1'b0;
        if (mem_req_ready) begin
          state_d = wr_q ? FS_IDLE : FS_WAIT;
          core_ce = wr_q;
        end
      end
      FS_WAIT: begin
        core_ce = 1'b0;
        if (mem_rsp_valid) begin
          state_d   = FS_IDLE;
          core_ce   = 1'b1;
          fill_done = 1'b1;
          fill_we   = !stale_q && !base_chg;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      stale_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      maddr_q <= '0;
    end else if (start) begin
      wr_q    <= !rd_req;
      stale_q <= 1'b0;
      addr_q  <= cons_addr;
      wdata_q <= cons_wdata;
      maddr_q <= rd_req ? line_addr : MEM_AW'(cons_addr);
    end else if (state_q != FS_IDLE && base_chg) begin
      stale_q <= 1'b1;
    end
  end

  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_req_write = wr_q;
  assign mem_req_addr  = maddr_q;
  assign mem_req_wdata = wdata_q;
  assign held_addr     = addr_q;
  assign in_idle       = (state_q == FS_IDLE);
endmodule

// File: rtl/cart_rom_cache.sv
module cart_rom_cache #(
  parameter int ADDR_W     = 23,
  parameter int MEM_AW     = 32,
  parameter int LINE_BYTES = 8,
  parameter int LINES      = 512,
  parameter int STALL_W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MEM_AW-1:0]       rom_base,
  input  logic                    cons_rd,
  input  logic                    cons_wr,
  input  logic [ADDR_W-1:0]       cons_addr,
  input  logic [7:0]              cons_wdata,
  output logic [7:0]              cons_rdata,
  output logic                    cons_rvalid,
  output logic                    core_ce,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [MEM_AW-1:0]       mem_req_addr,
  output logic [7:0]              mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [8*LINE_BYTES-1:0] mem_rsp_data,
  output logic [STALL_W-1:0]      stall_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = 8 * LINE_BYTES;

  logic [MEM_AW-1:0]  base_q;
  logic               base_chg;
  logic               raw_hit;
  logic               lookup_hit;
  logic               in_idle;
  logic               fill_we;
  logic               fill_done;
  logic [ADDR_W-1:0]  held_addr;
  logic [LINE_W-1:0]  lookup_line;
  logic [7:0]         hit_byte;
  logic [7:0]         fill_byte;
  logic [STALL_W-1:0] stall_q;

  always_ff @(posedge clk) begin
    base_q <= rom_base;
  end
  assign base_chg = rst_n && (rom_base != base_q);

  // a lookup in the cycle of a base change must not see the old image
  assign lookup_hit = raw_hit && !base_chg;

  crc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (base_chg),
    .rd_idx  (cons_addr[OFF_W +: IDX_W]),
    .rd_tag  (cons_addr[ADDR_W-1 -: TAG_W]),
    .raw_hit (raw_hit),
    .wr_en   (fill_we),
    .wr_idx  (held_addr[OFF_W +: IDX_W]),
    .wr_tag  (held_addr[ADDR_W-1 -: TAG_W])
  );

  crc_line_store #(.LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
    .clk     (clk),
    .wr_en   (fill_we),
    .wr_idx  (held_addr[OFF_W +: IDX_W]),
    .wr_line (mem_rsp_data),
    .rd_idx  (cons_addr[OFF_W +: IDX_W]),
    .rd_line (lookup_line)
  );

  crc_fill_fsm #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (cons_rd),
    .wr_req        (cons_wr),
    .lookup_hit    (lookup_hit),
    .base_chg      (base_chg),
    .rom_base      (rom_base),
    .cons_addr     (cons_addr),
    .cons_wdata    (cons_wdata),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .held_addr     (held_addr),
    .fill_we       (fill_we),
    .fill_done     (fill_done),
    .core_ce       (core_ce),
    .in_idle       (in_idle)
  );

  crc_byte_pick #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_pick_hit (
    .line_i (lookup_line),
    .off_i  (cons_addr[OFF_W-1:0]),
    .byte_o (hit_byte)
  );

  crc_byte_pick #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_pick_fill (
    .line_i (mem_rsp_data),
    .off_i  (held_addr[OFF_W-1:0]),
    .byte_o (fill_byte)
  );

  assign cons_rdata  = fill_done ? fill_byte : hit_byte;
  assign cons_rvalid = fill_done || (in_idle && cons_rd && lookup_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)        stall_q <= '0;
    else if (!core_ce) stall_q <= stall_q + STALL_W'(1);
  end
  assign stall_count = stall_q;
endmodule

// File: rtl/cart_rom_cache_chk.sv
module cart_rom_cache_chk #(
  parameter int MEM_AW  = 32,
  parameter int STALL_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cons_rd,
  input logic               core_ce,
  input logic               cons_rvalid,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [MEM_AW-1:0]  mem_req_addr,
  input logic [7:0]         mem_req_wdata,
  input logic [STALL_W-1:0] stall_count,
  input logic               base_chg,
  input logic               lookup_hit,
  input logic               in_idle
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R5
  stall_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ce |=> stall_count == $past(stall_count) + STALL_W'(1));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ce |=> $stable(stall_count));

  // R3
  hit_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && cons_rd && lookup_hit |=> !mem_req_valid);

  // R2
  rvalid_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_rvalid |-> core_ce);

  // R8
  req_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !core_ce || (mem_req_ready && mem_req_write));

  // R7
  base_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_chg |=> !lookup_hit);
endmodule

bind cart_rom_cache cart_rom_cache_chk #(.MEM_AW(MEM_AW), .STALL_W(STALL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cons_rd       (cons_rd),
  .core_ce       (core_ce),
  .cons_rvalid   (cons_rvalid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .stall_count   (stall_count),
  .base_chg      (base_chg),
  .lookup_hit    (lookup_hit),
  .in_idle       (in_idle)
);

// File: tb/cart_rom_cache_tb_top.sv
module cart_rom_cache_tb_top;
  localparam int ADDR_W = 23;
  localparam int MEM_AW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [MEM_AW-1:0] rom_base = 32'h0010_0000;
  logic              cons_rd = 1'b0;
  logic              cons_wr = 1'b0;
  logic [ADDR_W-1:0] cons_addr = '0;
  logic [7:0]        cons_wdata = '0;
  logic [7:0]        cons_rdata;
  logic              cons_rvalid;
  logic              core_ce;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic              mem_req_write;
  logic [MEM_AW-1:0] mem_req_addr;
  logic [7:0]        mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [63:0]       mem_rsp_data = '0;
  logic [31:0]       stall_count;

  always #2 clk = ~clk;

  cart_rom_cache dut_i (
    .clk(clk), .rst_n(rst_n), .rom_base(rom_base),
    .cons_rd(cons_rd), .cons_wr(cons_wr), .cons_addr(cons_addr),
    .cons_wdata(cons_wdata), .cons_rdata(cons_rdata),
    .cons_rvalid(cons_rvalid), .core_ce(core_ce),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .stall_count(stall_count)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  function automatic logic [7:0] img(input logic [31:0] a);
    return 8'(a[7:0] * 8'd3 + a[15:8] + a[23:16] * 8'd29 + 8'h11);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model
  int          ready_dly = 0;
  int          rsp_lat   = 1;
  int          wait_ctr  = 0;
  int          rsp_cnt   = 0;
  logic [31:0] rsp_addr  = '0;
  int          fills     = 0;
  int          writes    = 0;
  logic [31:0] last_raddr = '0;
  logic [31:0] last_waddr = '0;
  logic [7:0]  last_wdata = '0;
  bit          stray     = 1'b0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      rsp_cnt = 0; wait_ctr = 0; mem_req_ready = 1'b0;
    end else begin
      if (stray) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
        stray = 1'b0;
      end
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          for (int i = 0; i < 8; i++) mem_rsp_data[8*i +: 8] = img(rsp_addr + 32'(i));
        end
      end
      if (mem_req_valid) begin
        mem_req_ready = (wait_ctr >= ready_dly);
        if (mem_req_ready) begin
          wait_ctr = 0;
          if (mem_req_write) begin
            writes++; last_waddr = mem_req_addr; last_wdata = mem_req_wdata;
          end else begin
            fills++; last_raddr = mem_req_addr;
            rsp_addr = mem_req_addr; rsp_cnt = rsp_lat;
          end
        end else wait_ctr++;
      end else begin
        mem_req_ready = 1'b0; wait_ctr = 0;
      end
    end
  end

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always begin
    @(negedge clk); #1;
    if (rst_n && cons_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected read strobe", cons_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(cons_rdata == e, t, "read byte", cons_rdata, e);
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input string t, output int stl);
    int s0;
    @(negedge clk);
    cons_rd = 1'b1; cons_wr = 1'b0; cons_addr = a;
    exp_q.push_back(img(rom_base + 32'(a))); tag_q.push_back(t);
    s0 = int'(stall_count);
    #1;
    while (!core_ce) begin @(negedge clk); #1; end
    stl = int'(stall_count) - s0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, output int stl);
    int s0;
    @(negedge clk);
    cons_rd = 1'b0; cons_wr = 1'b1; cons_addr = a; cons_wdata = d;
    s0 = int'(stall_count);
    #1;
    while (!core_ce) begin @(negedge clk); #1; end
    stl = int'(stall_count) - s0;
  endtask

  task automatic idle();
    @(negedge clk);
    cons_rd = 1'b0; cons_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  localparam logic [ADDR_W-1:0] A_ADDR = 23'h000108;
  localparam logic [ADDR_W-1:0] B_ADDR = 23'h001108;

  initial begin
    int s;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(core_ce == 1'b1, "R1", "core_ce after reset", core_ce, 1);
    chk(mem_req_valid == 1'b0, "R1", "req after reset", mem_req_valid, 0);
    chk(stall_count == 0, "R1", "stall after reset", stall_count, 0);
    chk(cons_rvalid == 1'b0, "R1", "rvalid after reset", cons_rvalid, 0);

    // R2 miss, R5 stall cost
    ready_dly = 0; rsp_lat = 1;
    rd(A_ADDR, "R2", s);
    chk(s == 2, "R5", "miss stall", s, 2);
    chk(last_raddr == rom_base + 32'h108, "R2", "line address", last_raddr, rom_base + 32'h108);
    idle();

    // R3 hit, other offset, no request
    f0 = fills;
    rd(A_ADDR + 23'd5, "R3", s);
    chk(s == 0, "R3", "hit stall", s, 0);
    idle();
    chk(fills == f0, "R3", "fills on hit", fills, f0);

    // R6 back-to-back hits
    for (int i = 0; i < 8; i++) begin
      rd({A_ADDR[ADDR_W-1:3], 3'(i)}, "R6", s);
      chk(s == 0, "R6", "consecutive hit stall", s, 0);
    end
    idle();

    // R5 back-pressure and long latency, R9 holding
    ready_dly = 2; rsp_lat = 3;
    rd(23'h000230, "R9", s);
    chk(s == 6, "R5", "stall with backpressure", s, 6);
    idle();

    // R4 conflicting index
    ready_dly = 0; rsp_lat = 1;
    f0 = fills;
    rd(B_ADDR, "R4", s);
    chk(s == 2, "R4", "conflict miss stall", s, 2);
    rd(A_ADDR, "R4", s);
    chk(s == 2, "R4", "evicted line miss stall", s, 2);
    idle();
    chk(fills == f0 + 2, "R4", "fill count", fills, f0 + 2);

    // R8 write bypass, line untouched
    ready_dly = 1;
    wr(A_ADDR, 8'hEE, s);
    chk(s == 2, "R8", "write stall", s, 2);
    chk(last_waddr == 32'(A_ADDR), "R8", "write address", last_waddr, 32'(A_ADDR));
    chk(last_wdata == 8'hEE, "R8", "write data", last_wdata, 8'hEE);
    idle();
    ready_dly = 0;
    f0 = fills;
    rd(A_ADDR, "R8", s);
    chk(s == 0, "R8", "read after write still hits", s, 0);
    idle();
    chk(fills == f0, "R8", "no fill after write", fills, f0);

    // R9 stray response ignored
    stray = 1'b1;
    @(negedge clk); #1;
    chk(cons_rvalid == 1'b0, "R9", "stray response strobe", cons_rvalid, 0);

    // R7 base change with read in same cycle
    @(negedge clk);
    rom_base = 32'h0020_0000;
    cons_rd = 1'b1; cons_addr = A_ADDR;
    exp_q.push_back(img(rom_base + 32'(A_ADDR))); tag_q.push_back("R7");
    begin
      int s0;
      s0 = int'(stall_count);
      #1;
      while (!core_ce) begin @(negedge clk); #1; end
      s = int'(stall_count) - s0;
    end
    chk(s == 2, "R7", "miss after base change", s, 2);
    chk(last_raddr == 32'h0020_0108, "R7", "new base address", last_raddr, 32'h0020_0108);
    idle();

    // R10 base change during fill
    ready_dly = 3; rsp_lat = 2;
    fork
      rd(23'h000340, "R10", s);
      begin repeat (2) @(negedge clk); rom_base = 32'h0030_0000; end
    join
    chk(s == 6, "R10", "stall with base change", s, 6);
    idle();
    ready_dly = 0; rsp_lat = 1;
    rd(23'h000340, "R10", s);
    chk(s == 2, "R10", "line not kept", s, 2);
    idle();

    // R1 reset invalidates
    rd(23'h000340, "R1", s);
    chk(s == 0, "R1", "hit before reset", s, 0);
    idle();
    do_reset();
    rd(23'h000340, "R1", s);
    chk(s == 2, "R1", "miss after reset", s, 2);
    idle();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "pending reads", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule